// File: doc/BRIEF.md
# USB Host Controller Functional State Tracker

This block holds the two-bit functional state of a USB host controller: reset, resume, operational and suspend. Software changes the state through a register write port. A hardware reset forces the reset state. A software reset forces the suspend state. While the controller is suspended and a downstream port reports resume signalling, the hardware moves itself to resume.

On entry to the operational state, the block waits a programmable number of clock cycles (one millisecond in a real system) and then raises a start-of-frame enable. It drops that enable as soon as the state leaves operational. The block also keeps three configuration bits: interrupt routing, remote-wakeup-connected and remote-wakeup-enable. A hardware reset clears all three. A software reset clears only the enable. When the enable is set, a resume detection becomes a wake request to the host system.

After a hardware reset, the block asks the root hub to drive reset signalling on its downstream ports. It holds that request until the state leaves reset.

Top module: `usb_hcfs_top`

## Requirements
- R1: The state output encodes reset as 0, resume as 1, operational as 2 and suspend as 3. While and after a hardware reset (`hw_rst_n` low), the state is 0, and `sof_en`, `wake_req`, `int_route`, `rwake_conn` and `rwake_en` are all 0.
- R2: After a hardware reset, `port_rst_req` is 1. It falls on the clock edge at which the state leaves 0, and it stays 0 until the next hardware reset. A software write of state 0 does not raise it.
- R3: `sw_rst` high at a clock edge sets the state to 3 (suspend). It overrides a register write and a resume detection in the same cycle.
- R4: `sw_rst` leaves `int_route` and `rwake_conn` unchanged and clears `rwake_en`. It also overrides a write of these bits in the same cycle.
- R5: `wr_en` high at a clock edge (with no `sw_rst`) loads `wr_state`, `wr_route`, `wr_rwconn` and `wr_rwen` into the outputs at that edge.
- R6: In state 3 with `resume_det` high and no write or software reset, the state becomes 1 at the next edge. A write in the same cycle wins over this move.
- R7: Outside state 3, with no write and no software reset, the state never changes, whatever `resume_det` does.
- R8: `sof_en` rises exactly SOF_DELAY clock edges after the edge at which the state became 2. A write of 2 while already in state 2 does not restart the count.
- R9: `sof_en` falls at the same edge at which the state leaves 2. A later re-entry into state 2 starts a full new SOF_DELAY count.
- R10: `wake_req` is 1 in the cycle after a cycle in which `rwake_en` and `resume_det` are both 1, and it is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_rst | input | 1 | Synchronous software reset request |
| wr_en | input | 1 | Register write strobe |
| wr_state | input | 2 | Functional state value to write |
| wr_route | input | 1 | Interrupt routing value to write |
| wr_rwconn | input | 1 | Remote-wakeup-connected value to write |
| wr_rwen | input | 1 | Remote-wakeup-enable value to write |
| resume_det | input | 1 | Resume signalling seen on a downstream port |
| state | output | 2 | Current functional state |
| sof_en | output | 1 | Start-of-frame generation enable |
| wake_req | output | 1 | Remote wakeup request to the host system |
| int_route | output | 1 | Interrupt routing bit |
| rwake_conn | output | 1 | Remote-wakeup-connected bit |
| rwake_en | output | 1 | Remote-wakeup-enable bit |
| port_rst_req | output | 1 | Request for reset signalling on downstream ports |

## Verification
Every result except one is due on the clock edge right after the inputs that cause it: the state, the configuration bits, the port reset request and the wake request. The exception is `sof_en`, which rises SOF_DELAY edges after entry into operational and falls on the very edge at which the state leaves operational. The driver applies inputs at the falling edge. It pushes the outputs expected after the next rising edge, computed from the requirements, into a queue. The monitor pops one entry a few nanoseconds after each rising edge, so every comparison falls in the exact cycle its result is due, including each cycle of the SOF delay window.

// File: rtl/usb_hcfs_pkg.sv
package usb_hcfs_pkg;
    typedef enum logic [1:0] {
        HCFS_RESET   = 2'd0,
        HCFS_RESUME  = 2'd1,
        HCFS_OPER    = 2'd2,
        HCFS_SUSPEND = 2'd3
    } hcfs_e;
endpackage

// File: rtl/usb_hcfs_state.sv
module usb_hcfs_state
    import usb_hcfs_pkg::*;
(
    input  logic  clk,
    input  logic  hw_rst_n,
    input  logic  sw_rst,
    input  logic  wr_en,
    input  logic [1:0] wr_state,
    input  logic  resume_det,
    output hcfs_e state_q_o,
    output hcfs_e state_d_o,
    output logic  port_rst_req
);
    typedef struct packed {
        hcfs_e st;
        logic  prt;
    } st_reg_t;

    st_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (sw_rst) begin
            r_d.st = HCFS_SUSPEND;
        end else if (wr_en) begin
            r_d.st = hcfs_e'(wr_state);
        end else if (r_q.st == HCFS_SUSPEND && resume_det) begin
            r_d.st = HCFS_RESUME;
        end
        r_d.prt = r_q.prt && (r_d.st == HCFS_RESET);
    end

    always_ff @(posedge clk or negedge hw_rst_n) begin
        if (!hw_rst_n) begin
            r_q.st  <= HCFS_RESET;
            r_q.prt <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_q_o    = r_q.st;
    assign state_d_o    = r_d.st;
    assign port_rst_req = r_q.prt;

    a_r3_sw_to_suspend: assert property (@(posedge clk) disable iff (!hw_rst_n)
        sw_rst |=> (state_q_o == HCFS_SUSPEND));
    a_r6_auto_resume: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (state_q_o == HCFS_SUSPEND && resume_det && !wr_en && !sw_rst) |=> (state_q_o == HCFS_RESUME));
    a_r7_no_auto_move: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (state_q_o != HCFS_SUSPEND && !wr_en && !sw_rst) |=> $stable(state_q_o));
    a_r2_prt_stays_low: assert property (@(posedge clk) disable iff (!hw_rst_n)
        !port_rst_req |=> !port_rst_req);
endmodule

// File: rtl/usb_hcfs_sof_timer.sv
module usb_hcfs_sof_timer
    import usb_hcfs_pkg::*;
#(
    parameter int unsigned SOF_DELAY = 48000
) (
    input  logic  clk,
    input  logic  hw_rst_n,
    input  hcfs_e state_q,
    input  hcfs_e state_d,
    output logic  sof_en
);
    localparam int unsigned CNT_W = $clog2(SOF_DELAY + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SOF_DELAY - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sof;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (state_d != HCFS_OPER || state_q != HCFS_OPER) begin
            t_d.cnt = '0;
            t_d.sof = 1'b0;
        end else if (!t_q.sof) begin
            if (t_q.cnt == LAST) begin
                t_d.sof = 1'b1;
            end else begin
                t_d.cnt = t_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge hw_rst_n) begin
        if (!hw_rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign sof_en = t_q.sof;

    a_r9_sof_only_oper: assert property (@(posedge clk) disable iff (!hw_rst_n)
        sof_en |-> (state_q == HCFS_OPER));
    a_r8_sof_after_oper: assert property (@(posedge clk) disable iff (!hw_rst_n)
        $rose(sof_en) |-> $past(state_q == HCFS_OPER));
endmodule

// File: rtl/usb_hcfs_cfg.sv
module usb_hcfs_cfg (
    input  logic clk,
    input  logic hw_rst_n,
    input  logic sw_rst,
    input  logic wr_en,
    input  logic wr_route,
    input  logic wr_rwconn,
    input  logic wr_rwen,
    input  logic resume_det,
    output logic int_route,
    output logic rwake_conn,
    output logic rwake_en,
    output logic wake_req
);
    typedef struct packed {
        logic route;
        logic rwc;
        logic rwe;
        logic wake;
    } cfg_t;

    cfg_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.wake = c_q.rwe && resume_det;
        if (sw_rst) begin
            c_d.rwe = 1'b0;
        end else if (wr_en) begin
            c_d.route = wr_route;
            c_d.rwc   = wr_rwconn;
            c_d.rwe   = wr_rwen;
        end
    end

    always_ff @(posedge clk or negedge hw_rst_n) begin
        if (!hw_rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign int_route  = c_q.route;
    assign rwake_conn = c_q.rwc;
    assign rwake_en   = c_q.rwe;
    assign wake_req   = c_q.wake;

    a_r4_sw_keeps_bits: assert property (@(posedge clk) disable iff (!hw_rst_n)
        sw_rst |=> (int_route == $past(int_route) && rwake_conn == $past(rwake_conn) && !rwake_en));
    a_r10_no_wake_when_off: assert property (@(posedge clk) disable iff (!hw_rst_n)
        !rwake_en |=> !wake_req);
endmodule

// File: rtl/usb_hcfs_top.sv
module usb_hcfs_top
    import usb_hcfs_pkg::*;
#(
    parameter int unsigned SOF_DELAY = 48000
) (
    input  logic       clk,
    input  logic       hw_rst_n,
    input  logic       sw_rst,
    input  logic       wr_en,
    input  logic [1:0] wr_state,
    input  logic       wr_route,
    input  logic       wr_rwconn,
    input  logic       wr_rwen,
    input  logic       resume_det,
    output logic [1:0] state,
    output logic       sof_en,
    output logic       wake_req,
    output logic       int_route,
    output logic       rwake_conn,
    output logic       rwake_en,
    output logic       port_rst_req
);
    hcfs_e st_q, st_d;

    usb_hcfs_state u_state (
        .clk          (clk),
        .hw_rst_n     (hw_rst_n),
        .sw_rst       (sw_rst),
        .wr_en        (wr_en),
        .wr_state     (wr_state),
        .resume_det   (resume_det),
        .state_q_o    (st_q),
        .state_d_o    (st_d),
        .port_rst_req (port_rst_req)
    );

    usb_hcfs_sof_timer #(.SOF_DELAY(SOF_DELAY)) u_sof (
        .clk      (clk),
        .hw_rst_n (hw_rst_n),
        .state_q  (st_q),
        .state_d  (st_d),
        .sof_en   (sof_en)
    );

    usb_hcfs_cfg u_cfg (
        .clk        (clk),
        .hw_rst_n   (hw_rst_n),
        .sw_rst     (sw_rst),
        .wr_en      (wr_en),
        .wr_route   (wr_route),
        .wr_rwconn  (wr_rwconn),
        .wr_rwen    (wr_rwen),
        .resume_det (resume_det),
        .int_route  (int_route),
        .rwake_conn (rwake_conn),
        .rwake_en   (rwake_en),
        .wake_req   (wake_req)
    );

    assign state = st_q;

    a_r5_write_loads: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (wr_en && !sw_rst) |=> (state == $past(wr_state) && int_route == $past(wr_route)));
endmodule

// File: tb/tb_usb_hcfs_top.sv
module tb_usb_hcfs_top;
    localparam int D = 12;

    logic clk = 1'b0;
    logic hw_rst_n = 1'b0;
    logic sw_rst = 1'b0, wr_en = 1'b0, wr_route = 1'b0, wr_rwconn = 1'b0, wr_rwen = 1'b0, resume_det = 1'b0;
    logic [1:0] wr_state = 2'd0;
    logic [1:0] state;
    logic sof_en, wake_req, int_route, rwake_conn, rwake_en, port_rst_req;

    always #10 clk = ~clk;

    usb_hcfs_top #(.SOF_DELAY(D)) dut (
        .clk(clk), .hw_rst_n(hw_rst_n), .sw_rst(sw_rst), .wr_en(wr_en),
        .wr_state(wr_state), .wr_route(wr_route), .wr_rwconn(wr_rwconn),
        .wr_rwen(wr_rwen), .resume_det(resume_det), .state(state),
        .sof_en(sof_en), .wake_req(wake_req), .int_route(int_route),
        .rwake_conn(rwake_conn), .rwake_en(rwake_en), .port_rst_req(port_rst_req)
    );

    typedef struct {
        logic [7:0] v;
        string      tag;
    } exp_t;

    exp_t q[$];
    int total = 0, bad = 0;
    bit done = 1'b0;

    // reference model, written from the requirements
    logic [1:0] m_st;
    logic m_route, m_rwc, m_rwe, m_prt, m_sof, m_wake;
    int   m_age;

    function automatic logic [7:0] pack_dut();
        return {state, sof_en, wake_req, int_route, rwake_conn, rwake_en, port_rst_req};
    endfunction

    function automatic logic [7:0] pack_model();
        return {m_st, m_sof, m_wake, m_route, m_rwc, m_rwe, m_prt};
    endfunction

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        m_st = 2'd0; m_route = 0; m_rwc = 0; m_rwe = 0; m_prt = 1; m_sof = 0; m_wake = 0; m_age = 0;
    endtask

    task automatic step(input bit sw, input bit we, input logic [1:0] ws, input bit wro,
                        input bit wrc, input bit wre, input bit rd, input string tag);
        logic [1:0] ns;
        exp_t e;
        @(negedge clk);
        sw_rst = sw; wr_en = we; wr_state = ws; wr_route = wro; wr_rwconn = wrc; wr_rwen = wre; resume_det = rd;
        ns = sw ? 2'd3 : we ? ws : (m_st == 2'd3 && rd) ? 2'd1 : m_st;
        m_wake = m_rwe && rd;
        if (sw) m_rwe = 0;
        else if (we) begin m_route = wro; m_rwc = wrc; m_rwe = wre; end
        m_prt = m_prt && (ns == 2'd0);
        if (ns != 2'd2 || m_st != 2'd2) begin m_age = 0; m_sof = 0; end
        else if (!m_sof) begin m_age++; if (m_age == D) m_sof = 1; end
        m_st = ns;
        e.v = pack_model(); e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 2'd0, 0, 0, 0, 0, tag);
    endtask

    task automatic hw_reset();
        @(negedge clk);
        hw_rst_n = 0; sw_rst = 0; wr_en = 0; resume_det = 0;
        repeat (2) @(negedge clk);
        model_reset();
        check(pack_dut(), pack_model(), "R1 in reset");
        hw_rst_n = 1;
        #1;
        check(pack_dut(), pack_model(), "R2 after reset");
    endtask

    // monitor: compare one expected entry shortly after each rising edge
    always @(posedge clk) begin
        #5;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(pack_dut(), e.v, e.tag);
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        hw_reset();
        // R5: write config bits, state stays reset, R2 port request kept
        step(0, 1, 2'd0, 1, 1, 1, 0, "R5 write cfg, R2 prt kept");
        idle(2, "R2 prt held in reset");
        // R8: enter operational and count the delay
        step(0, 1, 2'd2, 1, 1, 1, 0, "R5 write oper, R2 prt falls");
        idle(5, "R8 counting");
        step(0, 1, 2'd2, 1, 1, 1, 0, "R8 rewrite oper no restart");
        idle(D, "R8 sof rise");
        // R7 and R10: resume_det while operational
        step(0, 0, 2'd0, 0, 0, 0, 1, "R7 no move, R10 wake");
        step(0, 0, 2'd0, 0, 0, 0, 0, "R10 wake drop");
        // R9: leave operational
        step(0, 1, 2'd3, 1, 1, 1, 0, "R9 sof drop on suspend");
        step(0, 0, 2'd0, 0, 0, 0, 1, "R6 auto resume");
        step(0, 0, 2'd0, 0, 0, 0, 1, "R7 resume stays");
        // R6: write wins over autonomous move
        step(0, 1, 2'd3, 1, 1, 1, 0, "R5 back to suspend");
        step(0, 1, 2'd2, 1, 1, 1, 1, "R6 write wins");
        idle(4, "R9 partial count");
        step(0, 1, 2'd1, 1, 1, 1, 0, "R9 leave before sof");
        step(0, 1, 2'd2, 1, 1, 1, 0, "R9 re-enter");
        idle(D + 2, "R9 full recount");
        // R3/R4: software reset beats write, keeps route bits
        step(1, 1, 2'd2, 0, 0, 1, 1, "R3 R4 sw reset wins");
        idle(2, "R4 bits kept");
        // R10: enable clear, resume_det gives no wake; R6 auto move still
        step(0, 0, 2'd0, 0, 0, 0, 1, "R10 no wake when off");
        step(0, 1, 2'd0, 0, 1, 0, 0, "R2 sw write reset no prt");
        idle(2, "R2 prt stays low");
        // R1: hardware reset clears everything
        step(0, 1, 2'd2, 1, 1, 1, 0, "R5 set all");
        idle(3, "R8 counting");
        wait (q.size() == 0);
        @(negedge clk);
        hw_reset();
        idle(3, "R1 idle after reset");
        wait (q.size() == 0);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule